// File: doc/BRIEF.md
# Register-Started MDIO Management Master

This block is the management-bus master of a larger chip. Software controls it through one 32-bit control word on a simple register bus. That word holds the target PHY address, the register address, the direction, an enable and a busy flag. For a write it also holds the data. Software starts a transaction by writing the word with both the enable and busy bits set. The engine then sends one clause-22 management frame on MDC/MDIO.

When the frame ends, the engine clears busy without any further software action. Software polls for busy to drop. For a read, the 16 bits returned by the PHY appear in the low half of the same word, and the address and command fields stay as they were written. MDC is the system clock divided by the parameter `CLK_DIV`. MDC rests high whenever no frame is in flight.

Top module: `mdio_master_engine`

## Requirements
- R1: The control word reads back on `reg_rd_data` as last accepted. Its fields are: data in [15:0], register address in [20:16], PHY address in [25:21], read command in bit 27 (1 = read, 0 = write), enable in bit 30 and busy in bit 31. After reset the word is zero.
- R2: A frame starts only when an accepted write has bit 31 and bit 30 both set. Any other accepted write is stored with bit 31 forced to 0, and MDC keeps no edge.
- R3: While busy is 1, register writes are ignored and the control word does not change until the frame ends.
- R4: A write frame has 64 bits sent MSB first: 32 ones, start `01`, opcode `01`, the 5-bit PHY address, the 5-bit register address, turnaround `10`, then the 16 data bits. The master drives MDIO (`mdio_oe` = 1) for all 64 bits.
- R5: A read frame uses opcode `10`. The master drives only the first 46 bits. It releases MDIO (`mdio_oe` = 0) for both turnaround bits and the 16 data bits. It samples the data bits MSB first on rising MDC edges.
- R6: Busy clears exactly 64 × `CLK_DIV` clock cycles after the starting write. After a read, [15:0] hold the sampled data and bits [30:16] keep their written values.
- R7: MDC has a period of `CLK_DIV` clock cycles and is low for `CLK_DIV`/2 of them. The master changes MDIO only while MDC is low.
- R8: With no frame in flight, MDC is high and `mdio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Value to write into the control word |
| reg_rd_data | output | 32 | Current control word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |
| mdio_i | input | 1 | Management data from the bus |

## Verification
The checks assume that the register bus presents one single-cycle write strobe at a time. They also assume that `mdio_i` is stable around each rising MDC edge, because the engine samples it then. The bench keeps to this in two ways. It drives every register write from the falling system-clock edge. Its PHY model changes `mdio_i` only on falling MDC edges, so data settles half an MDC period before each sample. The monitor ties each sampled bit to its position in the frame.

// File: rtl/mdio_eng_pkg.sv
// Package: shared field positions and frame layout of the management master.
// Assumes a clause-22 frame of 64 bits, the first 46 always driven by the master.
package mdio_eng_pkg;
    localparam int WORD_W      = 32;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 5;
    localparam int REG_LSB     = 16;
    localparam int PHY_LSB     = 21;
    localparam int RD_BIT      = 27;
    localparam int EN_BIT      = 30;
    localparam int BUSY_BIT    = 31;
    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = 64;
    localparam int HDR_BITS    = PRE_BITS + 2 + 2 + ADDR_W + ADDR_W;   // 46
    localparam int DATA_START  = HDR_BITS + 2;                         // 48
    localparam int IDX_W       = $clog2(FRAME_BITS);

    // Builds the full serial frame, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic              is_rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] regad,
        input logic [DATA_W-1:0] wdat);
        logic [1:0] op;
        logic [1:0] ta;
        op = is_rd ? 2'b10 : 2'b01;
        ta = is_rd ? 2'b11 : 2'b10;
        return {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad, ta, wdat};
    endfunction
endpackage

// File: rtl/mdio_ctrl_reg.sv
// Control word: holds data, addresses, command, enable and busy.
// Assumes one write strobe per cycle; writes while busy are dropped.
module mdio_ctrl_reg
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              done,
    input  logic [DATA_W-1:0] rd_result,
    output logic [WORD_W-1:0] word,
    output logic              start
);
    logic busy;
    assign busy = word[BUSY_BIT];

    // Start request: idle, and both busy and enable present in the write.
    always_comb begin
        start = wr_en && !busy && wr_data[BUSY_BIT] && wr_data[EN_BIT];
    end

    // Word update: accept when idle, finish on frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (done) begin
            word[BUSY_BIT] <= 1'b0;
            if (word[RD_BIT]) begin
                word[DATA_W-1:0] <= rd_result;
            end
        end else if (wr_en && !busy) begin
            word           <= wr_data;
            word[BUSY_BIT] <= start;
        end
    end
endmodule

// File: rtl/mdio_clk_div.sv
// Clock divider: emits fall, rise and period-end strobes while running.
// Assumes CLK_DIV is even and at least 2.
module mdio_clk_div #(
    parameter int CLK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic fall_tick,
    output logic rise_tick,
    output logic last_tick
);
    localparam int HALF  = CLK_DIV / 2;
    localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt;

    // Phase counter, held at zero when no frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe decode for the three phase points.
    always_comb begin
        fall_tick = run && (cnt == '0);
        rise_tick = run && (cnt == CNT_HALF);
        last_tick = run && (cnt == CNT_LAST);
    end
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer: shifts the 64-bit frame out, drives MDC, samples read data.
// Assumes start is only raised while idle; done is a one-cycle pulse.
module mdio_frame_seq
    import mdio_eng_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_rd,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] regad,
    input  logic [DATA_W-1:0] wdat,
    input  logic              fall_tick,
    input  logic              rise_tick,
    input  logic              last_tick,
    input  logic              mdio_i,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rd_result,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe
);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_HDR   = IDX_W'(HDR_BITS);
    localparam logic [IDX_W-1:0] IDX_DATA  = IDX_W'(DATA_START);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      bit_idx;
    logic                  rd_q;
    logic [DATA_W-1:0]     rd_sh;
    logic                  sample_now;
    logic [DATA_W-1:0]     rd_next;

    // Sample condition: rising MDC during the data field of a read.
    always_comb begin
        sample_now = active && rise_tick && rd_q && (bit_idx >= IDX_DATA);
        rd_next    = sample_now ? {rd_sh[DATA_W-2:0], mdio_i} : rd_sh;
        done       = active && last_tick && (bit_idx == IDX_LAST);
        rd_result  = rd_next;
    end

    // Frame progress, MDC level and MDIO drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bit_idx <= '0;
            shreg   <= '0;
            rd_q    <= 1'b0;
            rd_sh   <= '0;
            mdc     <= 1'b1;
            mdio_o  <= 1'b1;
            mdio_oe <= 1'b0;
        end else if (start) begin
            active  <= 1'b1;
            bit_idx <= '0;
            shreg   <= build_frame(is_rd, phy, regad, wdat);
            rd_q    <= is_rd;
            rd_sh   <= '0;
        end else if (active) begin
            rd_sh <= rd_next;
            if (fall_tick) begin
                mdc     <= 1'b0;
                mdio_o  <= shreg[FRAME_BITS-1];
                mdio_oe <= !rd_q || (bit_idx < IDX_HDR);
            end
            if (rise_tick) begin
                mdc <= 1'b1;
            end
            if (last_tick) begin
                if (bit_idx == IDX_LAST) begin
                    active  <= 1'b0;
                    mdio_oe <= 1'b0;
                    mdio_o  <= 1'b1;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                    shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_master_engine.sv
// Top: register-started clause-22 management master.
// Assumes a single writer on the register bus and CLK_DIV even, >= 2.
module mdio_master_engine
    import mdio_eng_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wr_data,
    output logic [31:0] reg_rd_data,
    output logic        mdc_o,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic [WORD_W-1:0] word;
    logic              start;
    logic              frame_done;
    logic              frame_active;
    logic [DATA_W-1:0] rd_result;
    logic              fall_tick;
    logic              rise_tick;
    logic              last_tick;

    mdio_ctrl_reg i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .done      (frame_done),
        .rd_result (rd_result),
        .word      (word),
        .start     (start)
    );

    mdio_clk_div #(.CLK_DIV(CLK_DIV)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (frame_active),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .last_tick (last_tick)
    );

    mdio_frame_seq i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_rd     (reg_wr_data[RD_BIT]),
        .phy       (reg_wr_data[PHY_LSB +: ADDR_W]),
        .regad     (reg_wr_data[REG_LSB +: ADDR_W]),
        .wdat      (reg_wr_data[DATA_W-1:0]),
        .fall_tick (fall_tick),
        .rise_tick (rise_tick),
        .last_tick (last_tick),
        .mdio_i    (mdio_i),
        .active    (frame_active),
        .done      (frame_done),
        .rd_result (rd_result),
        .mdc       (mdc_o),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    assign reg_rd_data = word;
endmodule

// File: rtl/mdio_master_engine_chk.sv
// Checker: protocol properties of the management master, bound to the top.
module mdio_master_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr_en,
    input logic [31:0] reg_wr_data,
    input logic [31:0] reg_rd_data,
    input logic        mdc_o,
    input logic        mdio_oe,
    input logic        frame_done
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_data[31] |-> (mdc_o && !mdio_oe));                                 // R8
    AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !reg_rd_data[31] && !(reg_wr_data[31] && reg_wr_data[30]))
        |=> !reg_rd_data[31]);                                                     // R2
    AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[31] && reg_wr_en && !frame_done) |=> (reg_rd_data == $past(reg_rd_data))); // R3
    AST_WRITE_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_data[31] && !reg_rd_data[27] && !mdc_o) |-> mdio_oe);              // R4
    AST_MDC_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc_o) |-> reg_rd_data[31]);                                         // R7
endmodule

bind mdio_master_engine mdio_master_engine_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .mdc_o       (mdc_o),
    .mdio_oe     (mdio_oe),
    .frame_done  (frame_done)
);

// File: tb/test_mdio_master_engine.sv
// Directed bench: one task per scenario, with a small PHY model on the bus.
module test_mdio_master_engine;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [31:0] reg_rd_data;
    logic        mdc_o, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // PHY model / monitor state
    logic        mon_en = 1'b0;
    int          rise_cnt = 0;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_val = '0;

    mdio_master_engine #(.CLK_DIV(DIV)) i_mdio_master_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .mdc_o(mdc_o), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i));

    always #2.5 clk = ~clk;

    // Monitor: record what the master presents at each rising MDC.
    always @(posedge mdc_o) begin
        if (mon_en && rise_cnt < 64) begin
            cap_o[63-rise_cnt]  = mdio_o;
            cap_oe[63-rise_cnt] = mdio_oe;
            rise_cnt = rise_cnt + 1;
        end
    end

    // PHY model: update data on falling MDC only.
    always @(negedge mdc_o) begin
        if (mon_en) begin
            if (rise_cnt >= 48 && rise_cnt < 64) mdio_i = phy_val[63-rise_cnt];
            else if (rise_cnt == 47)             mdio_i = 1'b0;
            else                                 mdio_i = 1'b1;
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [31:0] v);
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en   = 1'b0;
    endtask

    // Starts a frame and returns the number of cycles busy stayed high.
    task automatic run_frame(input logic [31:0] v, output int busy_cycles);
        rise_cnt = 0;
        mon_en   = 1'b1;
        busy_cycles = 0;
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = v;
        @(negedge clk);
        reg_wr_en = 1'b0;
        while (reg_rd_data[31] && busy_cycles < 1000) begin
            busy_cycles++;
            @(negedge clk);
        end
        mon_en = 1'b0;
    endtask

    function automatic logic [63:0] exp_frame(input logic [31:0] v);
        return {32'hFFFF_FFFF, 2'b01, (v[27] ? 2'b10 : 2'b01), v[25:21], v[20:16],
                (v[27] ? 2'b11 : 2'b10), v[15:0]};
    endfunction

    task automatic t_reset_state();
        @(negedge clk);
        chk(reg_rd_data == 32'h0, "R1 reset word", {32'h0, reg_rd_data}, 64'h0);
        chk(mdc_o == 1'b1 && mdio_oe == 1'b0, "R8 idle lines", {62'h0, mdc_o, mdio_oe}, 64'h2);
    endtask

    task automatic t_write_frame(input logic [31:0] v);
        int bc;
        run_frame(v, bc);
        chk(bc == 64*DIV, "R6 frame length", bc, 64*DIV);
        chk(cap_o == exp_frame(v), "R4 write frame bits", cap_o, exp_frame(v));
        chk(cap_oe == '1, "R4 write drive", cap_oe, '1);
        chk(reg_rd_data == (v & 32'h7FFF_FFFF), "R1 word after write", reg_rd_data, v & 32'h7FFF_FFFF);
        chk(mdc_o && !mdio_oe, "R8 idle after write", {mdc_o, mdio_oe}, 2'b10);
    endtask

    task automatic t_read_frame(input logic [31:0] v, input logic [15:0] pv);
        int bc;
        logic [31:0] exp;
        phy_val = pv;
        run_frame(v, bc);
        exp = (v & 32'h7FFF_0000) | {16'h0, pv};
        chk(cap_o[63:18] == exp_frame(v) >> 18, "R5 read header bits", {18'h0, cap_o[63:18]}, exp_frame(v) >> 18);
        chk(cap_oe == {{46{1'b1}}, 18'h0}, "R5 read release", cap_oe, {{46{1'b1}}, 18'h0});
        chk(reg_rd_data == exp, "R6 read result in word", reg_rd_data, exp);
        chk(bc == 64*DIV, "R6 read length", bc, 64*DIV);
    endtask

    task automatic t_write_while_busy();
        logic [31:0] first, second;
        first  = 32'hC000_0000 | (5'd3 << 21) | (5'd9 << 16) | 32'h00A5;
        second = 32'hC800_0000 | (5'd1 << 21) | (5'd2 << 16) | 32'h1234;
        rise_cnt = 0;
        mon_en   = 1'b1;
        reg_write(first);
        repeat (40) @(negedge clk);
        reg_write(second);
        @(negedge clk);
        chk(reg_rd_data == first, "R3 word held while busy", reg_rd_data, first);
        while (reg_rd_data[31]) @(negedge clk);
        mon_en = 1'b0;
        chk(cap_o == exp_frame(first), "R3 frame unaffected", cap_o, exp_frame(first));
        chk(reg_rd_data == (first & 32'h7FFF_FFFF), "R3 word after frame", reg_rd_data, first & 32'h7FFF_FFFF);
    endtask

    task automatic t_no_enable();
        int edges;
        logic prev;
        edges = 0;
        reg_write(32'h8000_1111);
        chk(reg_rd_data == 32'h0000_1111, "R2 busy without enable", reg_rd_data, 32'h0000_1111);
        reg_write(32'h4000_2222);
        chk(reg_rd_data == 32'h4000_2222, "R2 enable without busy", reg_rd_data, 32'h4000_2222);
        prev = mdc_o;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (mdc_o != prev) edges++;
            prev = mdc_o;
        end
        chk(edges == 0 && mdc_o, "R2 no MDC activity", edges, 0);
    endtask

    task automatic t_mdc_timing();
        int low_c, high_c;
        low_c = 0;
        high_c = 0;
        @(negedge clk);
        reg_wr_en   = 1'b1;
        reg_wr_data = 32'hC000_0000;
        @(negedge clk);
        reg_wr_en = 1'b0;
        while (mdc_o) @(negedge clk);
        while (!mdc_o) begin low_c++; @(negedge clk); end
        while (mdc_o)  begin high_c++; @(negedge clk); end
        chk(low_c == DIV/2, "R7 MDC low time", low_c, DIV/2);
        chk(low_c + high_c == DIV, "R7 MDC period", low_c + high_c, DIV);
        while (reg_rd_data[31]) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_write_frame(32'hC000_0000 | (5'd17 << 21) | (5'd22 << 16) | 32'hBEEF);
        t_write_frame(32'hC000_0000 | (5'd0 << 21) | (5'd31 << 16) | 32'h0001);
        t_read_frame(32'hC800_0000 | (5'd4 << 21) | (5'd2 << 16), 16'hD041);
        t_read_frame(32'hC800_0000 | (5'd31 << 21) | (5'd1 << 16) | 32'hFFFF, 16'h8001);
        t_write_while_busy();
        t_no_enable();
        t_mdc_timing();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule